// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs an external 12-bit converter that has a parallel output bus. It pulls the start-conversion line low for a short pulse. The rising edge of that line makes the converter hold its input and begin converting. The block then waits for the converter's active-low end-of-conversion pulse. When that pulse arrives it drives chip-select and read low together and samples the data bus in the last read cycle. Each result leaves the block as a one-cycle valid strobe with the 12-bit word.

Before it issues the next start edge, the sequencer waits until three conditions hold. First, the programmed sample period has passed since the last start. Second, the acquisition time has passed since the last end of conversion. Third, the read-to-start gap has passed since the last read began. A start comes either from free-running operation or from a trigger pulse. A conversion that never reports its end is abandoned after a programmable number of cycles. The mode-select output is held high so that the converter stays in its parallel interface mode.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is asserted, convst, cs_n and rd_n are high, and smp_valid, overrun and timeout_flag are low.
- R2: A start pulse holds convst low for exactly START_W cycles. The conversion begins when convst rises.
- R3: cs_n and rd_n fall together exactly 3 clock edges after eoc_n falls during a conversion. They stay low for exactly RD_W cycles. An eoc_n pulse that arrives while no conversion is running starts no read.
- R4: db is sampled in the last cycle in which rd_n is low. smp_valid is high for one cycle only, in the first cycle with rd_n high again, and smp_data carries the sampled word.
- R5: Two consecutive rising edges of convst are at least cfg_period cycles apart.
- R6: A rising edge of convst comes at least ACQ_CYC cycles after the previous eoc_n fall. It also comes at least RD_GAP cycles after the previous rd_n fall.
- R7: With cfg_free_run = 1, conversions repeat without any request. With cfg_free_run = 0, no start occurs without a trig pulse, and each trig pulse gives exactly one conversion.
- R8: Suppose eoc_n does not fall within cfg_timeout cycles (cfg_timeout ≥ 1) after convst rises. Then timeout_flag goes high exactly cfg_timeout cycles after that rise and stays high until reset. No read takes place for that conversion, and the sequencer goes back to idle and converts again.
- R9: overrun is set and stays set until reset when a new sample arrives while the previous one has had no smp_ack pulse. A single smp_ack pulse clears the pending state.
- R10: mode_par is always driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_free_run | input | 1 | 1: start conversions continuously; 0: start one conversion per trig pulse |
| trig | input | 1 | Single-cycle conversion request used in triggered mode |
| cfg_period | input | CW (16) | Minimum number of cycles between start edges |
| cfg_timeout | input | CW (16) | Number of cycles allowed for end-of-conversion after a start edge |
| convst | output | 1 | Start-conversion line; the conversion starts on its rising edge |
| eoc_n | input | 1 | End-of-conversion pulse from the converter, active low, asynchronous |
| cs_n | output | 1 | Converter chip-select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| db | input | DW (12) | Converter data bus |
| mode_par | output | 1 | Interface mode select, held high for parallel operation |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | DW (12) | Most recent sample |
| smp_ack | input | 1 | Consumer acknowledge of the pending sample |
| overrun | output | 1 | Sticky flag: a sample was lost to overrun |
| timeout_flag | output | 1 | Sticky flag: end-of-conversion did not arrive in time |

## Verification
The bench measures every interval in clock cycles from the edge it drove or observed. The read strobe is due on the third edge after the bench pulls eoc_n low, which covers two synchronizer stages plus the state change. The sample strobe is due in the same cycle that rd_n returns high, and timeout_flag is due exactly cfg_timeout cycles after the start edge. Spacing between start edges is not fixed, so the bench checks it as a lower bound against the period, acquisition and read-gap limits. Every port is sampled on the falling clock edge, so each check reads the value that settled after the rising edge it counts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_CONV  = 2'd2,
    ST_READ  = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_GAPS   = 3;
  localparam int unsigned GAP_PERIOD = 0;
  localparam int unsigned GAP_ACQ    = 1;
  localparam int unsigned GAP_READ   = 2;
endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_n_i,
  output logic fall_o
);
  logic [2:0] sync_q;
  logic [2:0] sync_d;

  always_comb sync_d = {sync_q[1:0], eoc_n_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= sync_d;
  end

  // stage 2 is the settled value, stage 3 its previous cycle
  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          met_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign met_o = (cnt_q >= limit_i);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter int unsigned START_W = 2,
  parameter int unsigned RD_W    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_free_run_i,
  input  logic          trig_i,
  input  logic [CW-1:0] cfg_timeout_i,
  input  logic          gaps_met_i,
  input  logic          eoc_fall_i,
  output logic          convst_o,
  output logic          rd_act_o,
  output logic          cap_en_o,
  output logic          ev_start_o,
  output logic          ev_eoc_o,
  output logic          timeout_o
);
  localparam logic [CW-1:0] START_LAST = CW'(START_W - 1);
  localparam logic [CW-1:0] RD_LAST    = CW'(RD_W - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          trig_pend_q, trig_pend_d;
  logic          timeout_q, timeout_d;
  logic          go;
  logic          conv_expired;

  assign go           = gaps_met_i && (cfg_free_run_i || trig_pend_q);
  assign conv_expired = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_timeout_i};

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    timeout_d   = timeout_q;
    trig_pend_d = trig_pend_q;
    cap_en_o    = 1'b0;
    ev_start_o  = 1'b0;
    ev_eoc_o    = 1'b0;
    if (trig_i && !cfg_free_run_i) trig_pend_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d     = ST_START;
          cnt_d       = '0;
          trig_pend_d = 1'b0;
        end
      end
      ST_START: begin
        if (cnt_q == START_LAST) begin
          state_d    = ST_CONV;
          cnt_d      = '0;
          ev_start_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (eoc_fall_i) begin
          state_d  = ST_READ;
          cnt_d    = '0;
          ev_eoc_o = 1'b1;
        end else if (conv_expired) begin
          state_d   = ST_IDLE;
          timeout_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == RD_LAST) begin
          state_d  = ST_IDLE;
          cap_en_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      trig_pend_q <= 1'b0;
      timeout_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      trig_pend_q <= trig_pend_d;
      timeout_q   <= timeout_d;
    end
  end

  assign convst_o  = (state_q != ST_START);
  assign rd_act_o  = (state_q == ST_READ);
  assign timeout_o = timeout_q;

  assert_read_after_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && eoc_fall_i) |=> (state_q == ST_READ));

  assert_start_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(cfg_free_run_i || trig_pend_q));

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |=> timeout_q);
endmodule

// File: rtl/adc_sample_out.sv
module adc_sample_out #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en_i,
  input  logic [DW-1:0] db_i,
  input  logic          ack_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          overrun_o
);
  logic [DW-1:0] data_q, data_d;
  logic          valid_q, pend_q, pend_d, ovr_q, ovr_d;

  always_comb begin
    data_d = data_q;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    if (cap_en_i) begin
      data_d = db_i;
      pend_d = 1'b1;
      if (pend_q && !ack_i) ovr_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= cap_en_i;
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign overrun_o = ovr_q;

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned CW      = 16,
  parameter int unsigned START_W = 2,
  parameter int unsigned RD_W    = 3,
  parameter int unsigned ACQ_CYC = 40,
  parameter int unsigned RD_GAP  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_free_run,
  input  logic          trig,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_timeout,
  output logic          convst,
  input  logic          eoc_n,
  output logic          cs_n,
  output logic          rd_n,
  input  logic [DW-1:0] db,
  output logic          mode_par,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  input  logic          smp_ack,
  output logic          overrun,
  output logic          timeout_flag
);
  logic [1:0]          rst_pipe_q;
  logic                rst_core_n;
  logic                eoc_fall, rd_act, cap_en, ev_start, ev_eoc;
  logic [NUM_GAPS-1:0] gap_clr, gap_met;
  logic [CW-1:0]       gap_lim [NUM_GAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  adc_eoc_sync u_sync (
    .clk(clk), .rst_n(rst_core_n), .eoc_n_i(eoc_n), .fall_o(eoc_fall)
  );

  always_comb begin
    gap_lim[GAP_PERIOD] = cfg_period;
    gap_lim[GAP_ACQ]    = CW'(ACQ_CYC);
    gap_lim[GAP_READ]   = CW'(RD_GAP);
    gap_clr[GAP_PERIOD] = ev_start;
    gap_clr[GAP_ACQ]    = ev_eoc;
    gap_clr[GAP_READ]   = ev_eoc;
  end

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    adc_gap_timer #(.CW(CW)) u_gap (
      .clk(clk), .rst_n(rst_core_n), .clr_i(gap_clr[g]),
      .limit_i(gap_lim[g]), .met_o(gap_met[g])
    );
  end

  adc_seq_fsm #(.CW(CW), .START_W(START_W), .RD_W(RD_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .cfg_free_run_i(cfg_free_run), .trig_i(trig), .cfg_timeout_i(cfg_timeout),
    .gaps_met_i(&gap_met), .eoc_fall_i(eoc_fall),
    .convst_o(convst), .rd_act_o(rd_act), .cap_en_o(cap_en),
    .ev_start_o(ev_start), .ev_eoc_o(ev_eoc), .timeout_o(timeout_flag)
  );

  adc_sample_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_core_n), .cap_en_i(cap_en), .db_i(db),
    .ack_i(smp_ack), .valid_o(smp_valid), .data_o(smp_data), .overrun_o(overrun)
  );

  assign cs_n     = ~rd_act;
  assign rd_n     = ~rd_act;
  assign mode_par = 1'b1;
endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  localparam int START_W = 2;
  localparam int RD_W    = 3;
  localparam int ACQ_CYC = 40;
  localparam int RD_GAP  = 40;
  localparam int WD_LIM  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_free_run = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] cfg_period = 16'd20;
  logic [15:0] cfg_timeout = 16'd200;
  logic        convst, cs_n, rd_n, mode_par, smp_valid, overrun, timeout_flag;
  logic        eoc_n = 1'b1;
  logic        smp_ack = 1'b0;
  logic [11:0] db, smp_data;
  logic [11:0] cur_word = 12'h0;

  always #2.5 clk = ~clk;

  assign db = (!cs_n && !rd_n) ? cur_word : ~cur_word;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cfg_free_run(cfg_free_run), .trig(trig),
    .cfg_period(cfg_period), .cfg_timeout(cfg_timeout), .convst(convst),
    .eoc_n(eoc_n), .cs_n(cs_n), .rd_n(rd_n), .db(db), .mode_par(mode_par),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ack(smp_ack),
    .overrun(overrun), .timeout_flag(timeout_flag)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  bit ack_en = 1;
  int drop_req = 0, drop_done = 0, spur_req = 0, spur_done = 0, trig_sent = 0;
  int n_rise = 0, n_rdfall = 0, nsamp = 0, n_trig_starts = 0, to_checks = 0;
  int last_rise, last_eoc, last_rdfall, low_start, rdfall_cyc, to_rise;
  int remaining = 0, eoc_low = 0;
  bit prev_convst = 1, prev_rd = 1, to_active = 0, pend_m = 0, ovr_m = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit gap_ok(input int now, input int since, input int lim);
    return (now - since) >= lim;
  endfunction

  function automatic int lat_draw();
    return 3 + int'($urandom % 25);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      last_rise = -100000; last_eoc = -100000; last_rdfall = -100000;
      prev_convst = 1; prev_rd = 1; to_active = 0; pend_m = 0; ovr_m = 0;
      remaining = 0; eoc_low = 0; eoc_n = 1'b1; smp_ack = 1'b0;
    end else begin
      // monitor
      if (!convst && prev_convst) begin
        low_start = cyc;
        if (!cfg_free_run) begin
          check(n_trig_starts < trig_sent, "R7 start without trig", n_trig_starts, trig_sent);
          n_trig_starts++;
        end
      end
      if (convst && !prev_convst) begin
        check(cyc - low_start == START_W, "R2 start width", cyc - low_start, START_W);
        check(gap_ok(cyc, last_rise, int'(cfg_period)), "R5 period", cyc - last_rise, int'(cfg_period));
        check(gap_ok(cyc, last_eoc, ACQ_CYC), "R6 acquisition", cyc - last_eoc, ACQ_CYC);
        check(gap_ok(cyc, last_rdfall, RD_GAP), "R6 read gap", cyc - last_rdfall, RD_GAP);
        last_rise = cyc;
        n_rise++;
      end
      if (!rd_n && prev_rd) begin
        check(cs_n == 1'b0, "R3 cs_n with rd_n", int'(cs_n), 0);
        check(!to_active, "R8 read during timed-out conversion", 1, 0);
        check(cyc - last_eoc == 3, "R3 read latency", cyc - last_eoc, 3);
        rdfall_cyc = cyc; last_rdfall = cyc; n_rdfall++;
      end
      if (rd_n && !prev_rd) begin
        check(cyc - rdfall_cyc == RD_W, "R3 read width", cyc - rdfall_cyc, RD_W);
        check(smp_valid == 1'b1, "R4 valid strobe", int'(smp_valid), 1);
        check(smp_data == cur_word, "R4 sample word", int'(smp_data), int'(cur_word));
        if (pend_m) ovr_m = 1;
        pend_m = !ack_en;
        check(overrun == ovr_m, "R9 overrun", int'(overrun), int'(ovr_m));
        nsamp++;
      end else if (smp_valid) begin
        check(0, "R4 stray valid", 1, 0);
      end
      if (to_active) begin
        if (cyc - to_rise == int'(cfg_timeout) - 1)
          check(timeout_flag == 1'b0, "R8 flag early", int'(timeout_flag), 0);
        if (cyc - to_rise == int'(cfg_timeout)) begin
          check(timeout_flag == 1'b1, "R8 flag due", int'(timeout_flag), 1);
          to_active = 0; to_checks++;
        end
      end
      smp_ack = ack_en && smp_valid;
      // converter model
      if (convst && !prev_convst) begin
        cur_word = 12'($urandom);
        if (drop_req != drop_done) begin
          drop_done++; remaining = 0; to_active = 1; to_rise = cyc;
        end else begin
          remaining = lat_draw();
        end
      end else if (remaining > 0) begin
        remaining--;
        if (remaining == 0) begin
          eoc_n = 1'b0; eoc_low = 1 + int'($urandom % 3); last_eoc = cyc;
        end
      end else if (eoc_low > 0) begin
        eoc_low--;
        if (eoc_low == 0) eoc_n = 1'b1;
      end else if (spur_req != spur_done) begin
        spur_done++; eoc_n = 1'b0; eoc_low = 3;
      end
      prev_convst = convst;
      prev_rd = rd_n;
    end
  end

  always @(negedge clk) begin
    if (cyc >= WD_LIM && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIM);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_samples(input int n);
    int target;
    target = nsamp + n;
    while (nsamp < target) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    check(convst == 1'b1, "R1 convst", int'(convst), 1);
    check(cs_n == 1'b1 && rd_n == 1'b1, "R1 cs_n/rd_n", int'({cs_n, rd_n}), 3);
    check(smp_valid == 1'b0, "R1 valid", int'(smp_valid), 0);
    check(overrun == 1'b0 && timeout_flag == 1'b0, "R1 flags", int'({overrun, timeout_flag}), 0);
    check(mode_par == 1'b1, "R10 mode select", int'(mode_par), 1);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    int base, tcount;
    void'($urandom(32'd1234));
    do_reset();
    // free-running, acquisition dominates spacing (R5, R6, R7)
    cfg_free_run = 1'b1; cfg_period = 16'd20; cfg_timeout = 16'd200; ack_en = 1;
    wait_samples(15);
    // period dominates spacing
    cfg_period = 16'd150;
    wait_samples(10);
    check(mode_par == 1'b1, "R10 mode select running", int'(mode_par), 1);
    // triggered mode: idle without trig (R7)
    cfg_free_run = 1'b0;
    wait_cyc(100);
    base = n_rise;
    wait_cyc(300);
    check(n_rise == base, "R7 no start without trig", n_rise - base, 0);
    // stray end-of-conversion pulse while idle (R3)
    base = n_rdfall;
    spur_req++;
    wait_cyc(30);
    check(n_rdfall == base, "R3 stray eoc ignored", n_rdfall - base, 0);
    check(smp_valid == 1'b0, "R3 stray eoc no sample", int'(smp_valid), 0);
    // one conversion per trig pulse
    base = n_rise; tcount = 0;
    cfg_period = 16'd30;
    for (int k = 0; k < 8; k++) begin
      wait_cyc(int'($urandom % 60));
      trig_sent++;
      trig = 1'b1; @(negedge clk); trig = 1'b0;
      tcount++;
      wait_samples(1);
    end
    wait_cyc(300);
    check(n_rise - base == tcount, "R7 one start per trig", n_rise - base, tcount);
    // timeout on missing end-of-conversion (R8)
    do_reset();
    cfg_free_run = 1'b1; cfg_period = 16'd20; cfg_timeout = 16'd50;
    drop_req++;
    while (to_checks == 0) @(negedge clk);
    wait_samples(4);
    check(timeout_flag == 1'b1, "R8 flag sticky", int'(timeout_flag), 1);
    // overrun with no acknowledge (R9)
    do_reset();
    cfg_timeout = 16'd200; ack_en = 0;
    wait_samples(3);
    check(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
    ack_en = 1;
    wait_cyc(5);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule